// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This block takes two operands in signed-magnitude form, each a sign bit above a plain binary magnitude, and either adds them or subtracts the second from the first. The magnitudes never pass through the sign position. The block first works out the effective sign of the second operand. If the two signs agree, the magnitudes are summed. If they differ, the smaller magnitude is taken from the larger. This is done with a single two's-complement addition. The end carry of that addition shows which operand was larger, and so it selects both the sign of the result and whether the raw difference has to be complemented back into a magnitude.

Each accepted operation produces one registered result together with a valid strobe one clock later. An overflow flag marks a same-sign sum whose magnitude does not fit. The operand width is a parameter. The result never carries a negative zero.

Top module: `sm_addsub`

## Requirements
- R1: Operands and result are WIDTH bits wide. Bit WIDTH-1 is the sign (0 positive, 1 negative) and bits WIDTH-2..0 hold the magnitude in plain unsigned binary.
- R2: With `op_sub` = 0 the block computes A + B. With `op_sub` = 1 it computes A - B by inverting the sign bit of B and then applying the addition rules.
- R3: When the sign of A equals the effective sign of B, the result magnitude is |A| + |B| and the result sign is the sign of A.
- R4: When the signs differ and |A| >= |B|, the result magnitude is |A| - |B| and the result sign is the sign of A.
- R5: When the signs differ and |A| < |B|, the result magnitude is |B| - |A| and the result sign is the effective sign of B. For example, 0_0011001 + 1_0100101 gives 1_0001100.
- R6: A result whose magnitude is zero always has sign bit 0.
- R7: `ovf` is 1 exactly when the signs agree and |A| + |B| exceeds 2^(WIDTH-1) - 1. In that case the magnitude is the low WIDTH-1 bits of the sum. A difference never sets `ovf`.
- R8: `res` and `ovf` update on the clock edge where `in_valid` is 1, and `out_valid` is 1 in the following cycle. In cycles where `in_valid` is 0, `res` and `ovf` hold their values and `out_valid` is 0.
- R9: A synchronous active-high `rst` clears `res`, `ovf` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op_sub | input | 1 | 0 adds, 1 subtracts B from A |
| opa | input | WIDTH | Operand A, signed magnitude |
| opb | input | WIDTH | Operand B, signed magnitude |
| res | output | WIDTH | Registered signed-magnitude result |
| ovf | output | 1 | Magnitude overflow of a same-sign sum |
| out_valid | output | 1 | Result registered from a valid operation |

## Verification
The hardest situations to reach are on the difference path. One is where the end carry is absent and the raw difference must be complemented, with subtract mode flipping B's sign first. The other is where the two magnitudes are equal, so a negative-signed A would yield negative zero unless it is forced positive. The vector table reaches these with operand pairs that have equal magnitudes and opposite signs in both orders, with minus zero as an operand, and with maximum magnitudes of opposite sign. The same table drives the sum path into overflow from both signs, including a wrap to exactly zero.

// File: rtl/sm_pkg.sv
package sm_pkg;
  // which arithmetic path the magnitudes take
  typedef enum logic {
    PATH_SUM  = 1'b0,
    PATH_DIFF = 1'b1
  } sm_path_e;
endpackage

// File: rtl/sm_ripple_adder.sv
module sm_ripple_adder #(
  parameter int WIDTH = 7
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0] carry;

  assign carry[0] = cin;

  // one full-adder cell per bit, carry rippling upward
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic half_s;
    assign half_s     = a[i] ^ b[i];
    assign sum[i]     = half_s ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (half_s & carry[i]);
  end

  assign cout = carry[WIDTH];
endmodule

// File: rtl/sm_sign_unit.sv
module sm_sign_unit
  import sm_pkg::*;
(
  input  logic     sign_a,
  input  logic     sign_b,
  input  logic     op_sub,
  output logic     sign_b_eff,
  output sm_path_e path
);
  // R2: subtraction flips the sign of B before the addition rules apply
  assign sign_b_eff = sign_b ^ op_sub;
  assign path       = (sign_a == sign_b_eff) ? PATH_SUM : PATH_DIFF;
endmodule

// File: rtl/sm_mag_core.sv
module sm_mag_core
  import sm_pkg::*;
#(
  parameter int MAGW = 7
) (
  input  logic [MAGW-1:0] mag_a,
  input  logic [MAGW-1:0] mag_b,
  input  sm_path_e        path,
  output logic [MAGW-1:0] mag_out,
  output logic            carry_out,
  output logic            borrow
);
  logic            is_diff;
  logic [MAGW-1:0] b_term;
  logic [MAGW-1:0] raw;
  logic            raw_carry;
  logic [MAGW-1:0] neg_raw;
  logic            neg_carry;

  assign is_diff = (path == PATH_DIFF);
  // difference path: A + ~B + 1, i.e. A plus the two's complement of B
  assign b_term  = is_diff ? ~mag_b : mag_b;

  sm_ripple_adder #(.WIDTH(MAGW)) u_main (
    .a    (mag_a),
    .b    (b_term),
    .cin  (is_diff),
    .sum  (raw),
    .cout (raw_carry)
  );

  // correction: two's complement of the raw difference
  sm_ripple_adder #(.WIDTH(MAGW)) u_fix (
    .a    (~raw),
    .b    ({MAGW{1'b0}}),
    .cin  (1'b1),
    .sum  (neg_raw),
    .cout (neg_carry)
  );

  // missing end carry on the difference path means |A| < |B|
  assign borrow    = is_diff & ~raw_carry;
  assign mag_out   = borrow ? neg_raw : raw;
  assign carry_out = raw_carry;

  logic unused_fix;
  assign unused_fix = neg_carry;
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import sm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res,
  output logic             ovf,
  output logic             out_valid
);
  // R1: top bit is sign, remaining bits are magnitude
  localparam int MAGW = WIDTH - 1;
  localparam int SB   = WIDTH - 1;

  logic            sign_b_eff;
  sm_path_e        path;
  logic [MAGW-1:0] mag_r;
  logic            carry_r;
  logic            borrow_r;
  logic            sign_next;
  logic            ovf_next;

  sm_sign_unit u_sign (
    .sign_a     (opa[SB]),
    .sign_b     (opb[SB]),
    .op_sub     (op_sub),
    .sign_b_eff (sign_b_eff),
    .path       (path)
  );

  sm_mag_core #(.MAGW(MAGW)) u_core (
    .mag_a     (opa[MAGW-1:0]),
    .mag_b     (opb[MAGW-1:0]),
    .path      (path),
    .mag_out   (mag_r),
    .carry_out (carry_r),
    .borrow    (borrow_r)
  );

  always_comb begin
    if (mag_r == '0)   sign_next = 1'b0;        // R6
    else if (borrow_r) sign_next = sign_b_eff;  // R5
    else               sign_next = opa[SB];     // R3, R4
    ovf_next = (path == PATH_SUM) & carry_r;    // R7
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      ovf       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res <= {sign_next, mag_r};
        ovf <= ovf_next;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res) && $stable(ovf))); // R8
  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(res[SB] && (res[MAGW-1:0] == '0))); // R6
  AST_NO_OVF_ON_DIFF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opa[SB] != (opb[SB] ^ op_sub))) |=> !ovf); // R7
  AST_DIFF_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opa[SB] != (opb[SB] ^ op_sub))) |=>
      ((res[MAGW-1:0] <= $past(opa[MAGW-1:0])) ||
       (res[MAGW-1:0] <= $past(opb[MAGW-1:0])))); // R4
endmodule

// File: tb/sm_addsub_bench.sv
module sm_addsub_bench;
  localparam int WIDTH = 8;
  localparam int NVEC  = 18;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             op_sub = 1'b0;
  logic [WIDTH-1:0] opa = '0;
  logic [WIDTH-1:0] opb = '0;
  logic [WIDTH-1:0] res;
  logic             ovf;
  logic             out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  sm_addsub #(.WIDTH(WIDTH)) u_sm_addsub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .opa(opa), .opb(opb), .res(res), .ovf(ovf), .out_valid(out_valid)
  );

  // {op_sub, opa, opb, expected res, expected ovf}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 8'h05, 8'h03, 8'h08, 1'b0},  // R3 positive sum
    {1'b0, 8'h85, 8'h83, 8'h88, 1'b0},  // R3 negative sum
    {1'b0, 8'h19, 8'hA5, 8'h8C, 1'b0},  // R5 worked case
    {1'b0, 8'h25, 8'h99, 8'h0C, 1'b0},  // R4 A larger
    {1'b1, 8'h0A, 8'h03, 8'h07, 1'b0},  // R2 10-3
    {1'b1, 8'h03, 8'h0A, 8'h87, 1'b0},  // R2 3-10
    {1'b1, 8'h83, 8'h85, 8'h02, 1'b0},  // R5 -3-(-5)
    {1'b1, 8'h05, 8'h85, 8'h0A, 1'b0},  // R2 5-(-5)
    {1'b0, 8'h14, 8'h94, 8'h00, 1'b0},  // R6 20+(-20)
    {1'b0, 8'h94, 8'h14, 8'h00, 1'b0},  // R6 -20+20
    {1'b1, 8'h80, 8'h00, 8'h00, 1'b0},  // R6 -0 - 0
    {1'b0, 8'h40, 8'h40, 8'h00, 1'b1},  // R7 wrap to zero
    {1'b0, 8'h7F, 8'h7F, 8'h7E, 1'b1},  // R7 positive overflow
    {1'b0, 8'hFF, 8'hFF, 8'hFE, 1'b1},  // R7 negative overflow
    {1'b0, 8'h7F, 8'hFF, 8'h00, 1'b0},  // R7 max diff no ovf
    {1'b1, 8'hFF, 8'h7F, 8'hFE, 1'b1},  // R7 subtract overflow
    {1'b0, 8'h01, 8'hFF, 8'hFE, 1'b0},  // R5 1+(-127)
    {1'b0, 8'h00, 8'h00, 8'h00, 1'b0}   // R1 zero operands
  };

  task automatic check(input string req, input logic [WIDTH-1:0] got_r,
                       input logic got_o, input logic got_v,
                       input logic [WIDTH-1:0] exp_r, input logic exp_o,
                       input logic exp_v);
    checks++;
    if (got_r !== exp_r || got_o !== exp_o || got_v !== exp_v) begin
      fails++;
      $display("FAIL %s: res=%h ovf=%b vld=%b expected res=%h ovf=%b vld=%b",
               req, got_r, got_o, got_v, exp_r, exp_o, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", res, ovf, out_valid, 8'h00, 1'b0, 1'b0);
    rst = 1'b0;

    // vector table: one operation per cycle, checked one edge later
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {op_sub, opa, opb} = VEC[i][25:9];
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R1-table vec %0d", i), res, ovf, out_valid,
            VEC[i][8:1], VEC[i][0], 1'b1);
      in_valid = 1'b0;
    end

    // R8: idle input leaves result and flag unchanged
    @(negedge clk);
    op_sub = 1'b0; opa = 8'h7F; opb = 8'h7F; in_valid = 1'b1;
    @(negedge clk);
    check("R8 load", res, ovf, out_valid, 8'h7E, 1'b1, 1'b1);
    in_valid = 1'b0; opa = 8'h01; opb = 8'h02;
    @(negedge clk);
    check("R8 hold", res, ovf, out_valid, 8'h7E, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 hold2", res, ovf, out_valid, 8'h7E, 1'b1, 1'b0);

    // R8: back-to-back operations
    in_valid = 1'b1; opa = 8'h01; opb = 8'h02;
    @(negedge clk);
    check("R8 b2b first", res, ovf, out_valid, 8'h03, 1'b0, 1'b1);
    op_sub = 1'b1;
    @(negedge clk);
    check("R8 b2b second", res, ovf, out_valid, 8'h81, 1'b0, 1'b1);

    // R9: reset mid-run clears everything
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R9 mid-run", res, ovf, out_valid, 8'h00, 1'b0, 1'b0);
    rst = 1'b0; in_valid = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule